// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block keeps a free-running binary counter that serves as a shared time base, and pairs it with one compare frame that raises a timer interrupt. The counter starts from zero at reset and advances by one on every clock, whether or not the compare frame is armed. Software reaches everything through a small synchronous register bus whose words are `DATA_W` bits wide. The counter is presented zero-extended to two words, and the compare target is written as two words.

The compare frame uses a greater-or-equal test, so a deadline that has already passed still fires as soon as the frame is armed. A sticky hit flag drives a level-sensitive, active-high interrupt line. Software acknowledges the interrupt by clearing the arm bit. Reading the low counter word latches the upper word at that same moment, so a following read of the high word completes one coherent sample and no retry loop is needed. The bus is a plain register interface with no back-pressure: reads return data combinationally in the cycle they are presented, and writes take effect at the next clock edge.

Top module: `sbt_sys_timer`

## Requirements
- R1: After reset the counter is zero and increments by one on every clock edge. It wraps from 2^CNT_W-1 to 0. The counter bits above CNT_W always read as zero.
- R2: Reset clears the control register, both compare words and the counter, and holds `irq` low.
- R3: A read at offset 0x4 returns the low counter word of the current cycle and, at the next edge, latches the upper counter word into a holding register. A read at offset 0x8 returns that holding register, which keeps its value until the next low-word read.
- R4: The compare words are written and read back at offset 0xC (low) and offset 0x10 (high). Together they form a two-word target in which the high word is the upper half.
- R5: At any edge where the arm bit takes or keeps the value 1 and the zero-extended counter is greater than or equal to the target, the hit flag becomes 1. This includes a target that already lies in the past when the frame is armed.
- R6: While the arm bit is 0, the hit flag and `irq` stay 0, even if the counter is at or beyond the target.
- R7: A write of 0 to the arm bit clears the hit flag at the same edge, so `irq` is low from the next cycle.
- R8: `irq` is high exactly while the hit flag is set.
- R9: Offset 0x0 is the control register. Bit 0 is the arm bit and can be read and written. Bit 1 is the hit flag and is read-only: writes to bit 1 are ignored.
- R10: Once set, the hit flag stays set while the frame remains armed, even if the target is moved beyond the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter and all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register; the low two bits must be 0 |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; a low-word counter read latches the high word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | Level, active-high timer interrupt |

## Verification
The bench builds the block with CNT_W = 14 and DATA_W = 8. At those values the carry into the high word happens every 256 cycles and the counter wraps after 16384 cycles, so a run can reach the snapshot across a carry, the full wrap, and the zero bits above CNT_W. A high compare word of 0xFF places the target above anything the counter can reach, which exercises the unreachable case. The exact edge at which a future deadline fires is checked against a counter model kept in the bench.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CNT_HI = 3'd2,
    SEL_CMP_LO = 3'd3,
    SEL_CMP_HI = 3'd4
  } reg_sel_e;

  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_HIT_BIT = 1;
endpackage

// File: rtl/sbt_counter.sv
module sbt_counter #(
  parameter int CNT_W  = 56,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snap,
  output logic [2*DATA_W-1:0] cnt_wide,
  output logic [DATA_W-1:0]   held_hi
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;

  // zero-extend the counter to two bus words
  generate
    if (CNT_W < WIDE_W) begin : g_pad
      assign cnt_wide = {{(WIDE_W - CNT_W){1'b0}}, cnt_q};
    end else begin : g_full
      assign cnt_wide = cnt_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // upper word captured when the low word is read
  always_ff @(posedge clk) begin
    if (!rst_n)    hold_q <= '0;
    else if (snap) hold_q <= cnt_wide[WIDE_W-1:DATA_W];
  end

  assign held_hi = hold_q;

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> hold_q == $past(cnt_wide[WIDE_W-1:DATA_W]));

  a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold_q));
endmodule

// File: rtl/sbt_cmp_frame.sv
module sbt_cmp_frame #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] cnt_wide,
  input  logic                wr_ctrl,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] target,
  output logic                arm,
  output logic                hit
);
  import sbt_pkg::*;

  logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q;
  logic              arm_q, hit_q, arm_d, reached;

  assign target  = {tgt_hi_q, tgt_lo_q};
  assign reached = cnt_wide >= target;
  assign arm_d   = wr_ctrl ? wdata[CTRL_ARM_BIT] : arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else begin
      if (wr_lo) tgt_lo_q <= wdata;
      if (wr_hi) tgt_hi_q <= wdata;
    end
  end

  // hit follows the next arm value so a disarming write clears it at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      hit_q <= arm_d & (hit_q | reached);
    end
  end

  assign arm = arm_q;
  assign hit = hit_q;

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> !hit_q);

  a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !wr_ctrl && reached) |=> hit_q);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !wr_ctrl) |=> hit_q);
endmodule

// File: rtl/sbt_sys_timer.sv
module sbt_sys_timer #(
  parameter int CNT_W  = 56,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import sbt_pkg::*;

  localparam int WIDE_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              aligned;
  logic              snap, wr_ctrl, wr_lo, wr_hi;
  logic [WIDE_W-1:0] cnt_wide, target;
  logic [DATA_W-1:0] held_hi;
  logic              arm, hit;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign snap    = bus_rd && aligned && (sel == SEL_CNT_LO);
  assign wr_ctrl = bus_wr && aligned && (sel == SEL_CTRL);
  assign wr_lo   = bus_wr && aligned && (sel == SEL_CMP_LO);
  assign wr_hi   = bus_wr && aligned && (sel == SEL_CMP_HI);

  sbt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .snap     (snap),
    .cnt_wide (cnt_wide),
    .held_hi  (held_hi)
  );

  sbt_cmp_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wide (cnt_wide),
    .wr_ctrl  (wr_ctrl),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (bus_wdata),
    .target   (target),
    .arm      (arm),
    .hit      (hit)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_CTRL: begin
          bus_rdata[CTRL_ARM_BIT] = arm;
          bus_rdata[CTRL_HIT_BIT] = hit;
        end
        SEL_CNT_LO: bus_rdata = cnt_wide[DATA_W-1:0];
        SEL_CNT_HI: bus_rdata = held_hi;
        SEL_CMP_LO: bus_rdata = target[DATA_W-1:0];
        SEL_CMP_HI: bus_rdata = target[WIDE_W-1:DATA_W];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = hit;

  a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CTRL_ARM_BIT]) |=> !irq);

  a_r8_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> arm);
endmodule

// File: tb/sbt_sys_timer_tb.sv
module sbt_sys_timer_tb;
  localparam int CNT_W  = 14;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int unsigned exp_q[$];
  string       tag_q[$];

  logic [15:0] model_cnt = '0;
  logic [7:0]  model_held = '0;

  always #4 clk = ~clk;

  sbt_sys_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // independent model of the free counter
  always @(posedge clk) begin
    if (!rst_n) model_cnt <= '0;
    else        model_cnt <= (model_cnt + 16'd1) & 16'h3FFF;
  end

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      int unsigned e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e[7:0]) begin
        errors++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #2;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input int unsigned e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic rd_cnt_lo(input string tag);
    @(negedge clk);
    bus_addr = 5'h04; bus_rd = 1'b1;
    exp_q.push_back(int'(model_cnt[7:0])); tag_q.push_back(tag);
    model_held = model_cnt[15:8];
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic rd_cnt_hi(input string tag);
    rd_reg(5'h08, int'(model_held), tag);
  endtask

  initial begin
    #(8 * 60000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] tgt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    chk_irq(1'b0, "R2 irq after reset");
    rd_reg(5'h00, 0, "R2 ctrl reset");
    rd_reg(5'h0C, 0, "R2 cmp lo reset");
    rd_reg(5'h10, 0, "R2 cmp hi reset");

    // R1 / R3 coherent counter reads
    rd_cnt_lo("R1 counter lo early");
    rd_cnt_hi("R3 counter hi early");
    repeat (37) @(negedge clk);
    rd_cnt_lo("R1 counter lo later");
    rd_cnt_hi("R3 counter hi later");

    // R3 snapshot survives a carry into the high word
    rd_cnt_lo("R3 lo before carry");
    repeat (300) @(negedge clk);
    rd_cnt_hi("R3 hi held across carry");

    // R9 / R6 writes to hit bit ignored, disarmed frame silent with past target
    wr_reg(5'h00, 8'h02);
    rd_reg(5'h00, 0, "R9 hit bit write ignored");
    repeat (20) @(negedge clk);
    chk_irq(1'b0, "R6 no irq while disarmed");

    // R5 past deadline fires on arming
    wr_reg(5'h00, 8'h01);
    chk_irq(1'b1, "R5 past target fires");
    rd_reg(5'h00, 3, "R9 ctrl shows arm and hit");

    // R10 sticky when target moved beyond counter
    wr_reg(5'h10, 8'hFF);
    repeat (10) @(negedge clk);
    chk_irq(1'b1, "R10 hit sticky while armed");
    wr_reg(5'h00, 8'h01);
    rd_reg(5'h00, 3, "R10 rearm write keeps hit");

    // R7 acknowledge by disarming
    wr_reg(5'h00, 8'h00);
    chk_irq(1'b0, "R7 irq drops on disarm");
    rd_reg(5'h00, 0, "R7 ctrl cleared");

    // R4 unreachable target never fires
    wr_reg(5'h0C, 8'h5A);
    rd_reg(5'h0C, 'h5A, "R4 cmp lo readback");
    rd_reg(5'h10, 'hFF, "R4 cmp hi readback");
    wr_reg(5'h00, 8'h01);
    repeat (50) @(negedge clk);
    chk_irq(1'b0, "R4 target above counter range");
    wr_reg(5'h00, 8'h00);

    // R5 / R8 future deadline fires at the exact edge
    @(negedge clk);
    tgt = model_cnt + 16'd40;
    wr_reg(5'h0C, tgt[7:0]);
    wr_reg(5'h10, tgt[15:8]);
    wr_reg(5'h00, 8'h01);
    @(negedge clk);
    while (model_cnt != tgt) @(negedge clk);
    #2;
    checks++;
    if (irq !== 1'b0) begin
      errors++;
      $display("FAIL R5 irq before target edge: actual %0b expected 0", irq);
    end
    chk_irq(1'b1, "R8 irq on reaching target");
    wr_reg(5'h00, 8'h00);

    // R1 wrap and zero upper bits
    @(negedge clk);
    while (model_cnt != 16'd16370) @(negedge clk);
    rd_cnt_lo("R1 lo near top");
    rd_cnt_hi("R1 hi near top is 0x3F");
    repeat (30) @(negedge clk);
    rd_cnt_lo("R1 lo after wrap");
    rd_cnt_hi("R1 hi after wrap is zero");

    finished = 1'b1;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule